// File: doc/BRIEF.md
# Gate-Driver Fault Pulse Stretcher and Shutdown Controller

This block is the fault and shutdown sequencer of a low-side gate driver. It collects three already-filtered fault requests (supply undervoltage, overcurrent and desaturation) and the gate command. It also reads back a shared open-drain fault/shutdown pin through two comparator flags, one for the high threshold and one for the low threshold. From these it drives four enables: the main output driver, a slow soft-off sink, the fault-pin pull-down and the Miller clamp.

Any fault removes the main drive in the same cycle through a combinational path that bypasses the pin's RC delay. The block then pulls the fault pin low for at least `CLR_CYC` clock cycles, and longer if a fault is still present when that time is up. After the pull-down is released, the output stays off until the pin has been recharged externally and reads above its high threshold. A low on the pin driven from outside acts as a shutdown input.

The controller has four states:
- `ST_RUN`: the output follows the gate command.
- `ST_HOLD`: the pull-down and soft-off are active and the hold timer runs.
- `ST_RECOVER`: the pull-down is released and the block waits for the pin to read high.
- `ST_EXTSD`: an external shutdown is in progress.

The transitions are:
- any state to `ST_HOLD` on a fault;
- `ST_HOLD` to `ST_RECOVER` when the timer has expired and no fault remains;
- `ST_RECOVER` or `ST_EXTSD` to `ST_RUN` when the synchronised high flag reads 1;
- `ST_RUN` to `ST_EXTSD` when the synchronised low flag reads 1.

Reset enters `ST_RECOVER`.

Top module: `fault_sd_ctrl`

## Requirements
- R1: In `ST_RUN`, with no fault and no synchronised low flag, `drv_en` equals `gate_cmd`.
- R2: While any of `uv_flt`, `oc_flt` or `dsat_flt` is 1, `drv_en` is 0 in that same cycle.
- R3: `soft_off_en` is 1 while a fault input is 1 or the pull-down is held, and it is never 1 together with `drv_en`.
- R4: A fault sampled at a clock edge asserts `pull_dn_en` from that edge. A fault that lasts a single cycle gives a pull-down pulse of exactly `CLR_CYC` cycles.
- R5: A fault sampled on L consecutive edges gives a pull-down pulse of max(L, `CLR_CYC`) cycles.
- R6: A further fault that arrives while the pull-down is held extends the pulse to the edge after that fault clears. It never shortens the pulse or restarts the timer, so a short second fault leaves the pulse at `CLR_CYC`.
- R7: After the pull-down is released, `drv_en` stays 0 while `pin_hi_raw` is 0. Once `pin_hi_raw` rises, `drv_en` follows `gate_cmd` from the third rising edge on (two synchroniser flops plus the state register).
- R8: A `pin_lo_raw` of 1 with no fault forces `drv_en` to 0 from the second edge (after synchronisation) and does not assert `pull_dn_en`. The output resumes on the third edge after `pin_hi_raw` reads 1.
- R9: `clamp_en` is 1 exactly when `gate_cmd` is 0 and `gate_low` is 1.
- R10: During and after reset, `drv_en` and `pull_dn_en` are 0 and the output stays disabled until the pin reads high.
- R11: A fault during an external shutdown asserts `pull_dn_en` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_cmd | input | 1 | Gate command, high turns the switch on |
| uv_flt | input | 1 | Filtered supply-undervoltage fault |
| oc_flt | input | 1 | Overcurrent fault (after blanking) |
| dsat_flt | input | 1 | Desaturation fault (after blanking) |
| pin_hi_raw | input | 1 | Fault pin above high threshold, asynchronous |
| pin_lo_raw | input | 1 | Fault pin below low threshold, asynchronous |
| gate_low | input | 1 | Gate voltage below clamp threshold |
| drv_en | output | 1 | Main output driver enable |
| soft_off_en | output | 1 | Soft turn-off sink enable |
| pull_dn_en | output | 1 | Open-drain fault-pin pull-down enable |
| clamp_en | output | 1 | Miller clamp enable |

## Verification
The hardest situation to reach is a second fault that lands inside a running hold window. The timer must be neither restarted nor cut short by it, and the pin's own pull-down must feed back into the read-back flags.

The bench models the pin as a wired node: the pull-down, an external shutdown source and an RC-recharge delay together drive the two comparator flags. Fault pulses are issued at chosen cycle offsets from the start of the hold window, and each pull-down pulse is measured in cycles against max(fault length, `CLR_CYC`).

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RECOVER = 2'd2,
        ST_EXTSD   = 2'd3
    } fsd_state_e;
endpackage

// File: rtl/fsd_sync.sv
module fsd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic s1, s2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= d[gi];
                    s2 <= s1;
                end
            end
            assign q[gi] = s2;
        end
    endgenerate
endmodule

// File: rtl/fsd_hold_timer.sv
module fsd_hold_timer #(
    parameter int CLR_CYC = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_hold,
    output logic done
);
    localparam int CW = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLR_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!in_hold)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fsd_ctrl_fsm.sv
module fsd_ctrl_fsm
    import fsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_any,
    input  logic       pin_hi_s,
    input  logic       pin_lo_s,
    input  logic       hold_done,
    input  logic       gate_cmd,
    input  logic       gate_low,
    output fsd_state_e state,
    output logic       drv_en,
    output logic       soft_off_en,
    output logic       pull_dn_en,
    output logic       clamp_en
);
    fsd_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (flt_any) nxt = ST_HOLD;
                        else if (pin_lo_s) nxt = ST_EXTSD;
            ST_HOLD:    if (hold_done && !flt_any) nxt = ST_RECOVER;
            ST_RECOVER: if (flt_any) nxt = ST_HOLD;
                        else if (pin_hi_s) nxt = ST_RUN;
            ST_EXTSD:   if (flt_any) nxt = ST_HOLD;
                        else if (pin_hi_s) nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_RECOVER;
        else
            state <= nxt;
    end

    always_comb begin
        drv_en      = 1'b0;
        soft_off_en = flt_any;
        pull_dn_en  = 1'b0;
        clamp_en    = !gate_cmd && gate_low;
        unique case (state)
            ST_RUN:     drv_en = gate_cmd && !flt_any && !pin_lo_s;
            ST_HOLD: begin
                pull_dn_en  = 1'b1;
                soft_off_en = 1'b1;
            end
            ST_RECOVER: drv_en = 1'b0;
            ST_EXTSD:   drv_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/fault_sd_ctrl.sv
module fault_sd_ctrl
    import fsd_pkg::*;
#(
    parameter int CLR_CYC = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_cmd,
    input  logic uv_flt,
    input  logic oc_flt,
    input  logic dsat_flt,
    input  logic pin_hi_raw,
    input  logic pin_lo_raw,
    input  logic gate_low,
    output logic drv_en,
    output logic soft_off_en,
    output logic pull_dn_en,
    output logic clamp_en
);
    logic       flt_any;
    logic [1:0] pin_s;
    logic       hold_done;
    fsd_state_e state;

    assign flt_any = uv_flt | oc_flt | dsat_flt;

    fsd_sync #(.W(2)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_lo_raw, pin_hi_raw}),
        .q     (pin_s)
    );

    fsd_hold_timer #(.CLR_CYC(CLR_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_hold (state == ST_HOLD),
        .done    (hold_done)
    );

    fsd_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flt_any     (flt_any),
        .pin_hi_s    (pin_s[0]),
        .pin_lo_s    (pin_s[1]),
        .hold_done   (hold_done),
        .gate_cmd    (gate_cmd),
        .gate_low    (gate_low),
        .state       (state),
        .drv_en      (drv_en),
        .soft_off_en (soft_off_en),
        .pull_dn_en  (pull_dn_en),
        .clamp_en    (clamp_en)
    );
endmodule

// File: rtl/fsd_chk.sv
module fsd_chk #(
    parameter int CLR_CYC = 27500
) (
    input logic clk,
    input logic rst_n,
    input logic gate_cmd,
    input logic uv_flt,
    input logic oc_flt,
    input logic dsat_flt,
    input logic pin_hi_raw,
    input logic pin_lo_raw,
    input logic gate_low,
    input logic drv_en,
    input logic soft_off_en,
    input logic pull_dn_en,
    input logic clamp_en
);
    localparam int KW = $clog2(CLR_CYC + 1);
    localparam logic [KW-1:0] KMAX = KW'(CLR_CYC);

    logic [KW-1:0] pd_len;
    logic          flt;

    assign flt = uv_flt | oc_flt | dsat_flt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pd_len <= '0;
        else if (!pull_dn_en)
            pd_len <= '0;
        else if (pd_len != KMAX)
            pd_len <= pd_len + 1'b1;
    end

    // R2
    flt_cuts_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt |-> !drv_en);

    // R3
    soft_drv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(soft_off_en && drv_en));

    // R4
    pd_follows_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> pull_dn_en);

    // R4
    pd_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_dn_en) |-> (pd_len == KMAX));

    // R7
    no_drv_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_dn_en) |-> !drv_en);

    // R9
    clamp_off_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cmd |-> !clamp_en);

    // R8
    ext_sd_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt && !pull_dn_en && pin_lo_raw && !pin_hi_raw) |=> !pull_dn_en || $past(flt));
endmodule

bind fault_sd_ctrl fsd_chk #(.CLR_CYC(CLR_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_cmd    (gate_cmd),
    .uv_flt      (uv_flt),
    .oc_flt      (oc_flt),
    .dsat_flt    (dsat_flt),
    .pin_hi_raw  (pin_hi_raw),
    .pin_lo_raw  (pin_lo_raw),
    .gate_low    (gate_low),
    .drv_en      (drv_en),
    .soft_off_en (soft_off_en),
    .pull_dn_en  (pull_dn_en),
    .clamp_en    (clamp_en)
);

// File: tb/fault_sd_ctrl_bench.sv
`timescale 1ns/1ps
module fault_sd_ctrl_bench;
    localparam int CLR = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_cmd = 1'b0;
    logic uv_flt = 1'b0;
    logic oc_flt = 1'b0;
    logic dsat_flt = 1'b0;
    logic gate_low = 1'b0;
    logic ext_low = 1'b0;
    logic rc_hold = 1'b0;
    logic pin_hi_raw, pin_lo_raw;
    logic drv_en, soft_off_en, pull_dn_en, clamp_en;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // wired-pin model: pull-down, external source, RC recharge delay
    assign pin_lo_raw = pull_dn_en | ext_low;
    assign pin_hi_raw = !pull_dn_en && !ext_low && !rc_hold;

    fault_sd_ctrl #(.CLR_CYC(CLR)) u_fault_sd_ctrl (
        .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd),
        .uv_flt(uv_flt), .oc_flt(oc_flt), .dsat_flt(dsat_flt),
        .pin_hi_raw(pin_hi_raw), .pin_lo_raw(pin_lo_raw), .gate_low(gate_low),
        .drv_en(drv_en), .soft_off_en(soft_off_en),
        .pull_dn_en(pull_dn_en), .clamp_en(clamp_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // first fault on src1 for len1 cycles; optional second fault on uv at off2 for len2
    task automatic fault_run(input int src1, input int len1, input int off2,
                             input int len2, output int pd_cycles);
        pd_cycles = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (src1 == 0) oc_flt = (i < len1);
            else if (src1 == 1) dsat_flt = (i < len1);
            else uv_flt = (i < len1);
            if (len2 > 0) uv_flt = (i >= off2) && (i < off2 + len2);
            #1;
            if (pull_dn_en) pd_cycles++;
            else if (i > 0) break;
        end
        oc_flt = 1'b0; dsat_flt = 1'b0; uv_flt = 1'b0;
    endtask

    task automatic back_to_run();
        repeat (5) step();
    endtask

    typedef struct packed {
        logic gcmd;
        logic glow;
        logic exp_drv;
        logic exp_clamp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int pd;
        // R10: reset state
        gate_cmd = 1'b1;
        rc_hold = 1'b1;
        repeat (3) step();
        chk("R10 drv in reset", drv_en, 0);
        chk("R10 pd in reset", pull_dn_en, 0);
        rst_n = 1'b1;
        repeat (8) step();
        chk("R10 drv waits for pin high", drv_en, 0);
        @(negedge clk); rc_hold = 1'b0;
        step();
        step();
        chk("R10 drv after 2 edges", drv_en, 0);
        step();
        chk("R10 drv after 3 edges", drv_en, 1);

        // R1 / R9: vector table in run state
        foreach (VECS[k]) begin
            @(negedge clk);
            gate_cmd = VECS[k].gcmd;
            gate_low = VECS[k].glow;
            #1;
            chk("R1 drv follows cmd", drv_en, VECS[k].exp_drv);
            chk("R9 clamp", clamp_en, VECS[k].exp_clamp);
        end
        gate_low = 1'b0;
        gate_cmd = 1'b1;
        step();

        // R2 / R3: same-cycle cut
        @(negedge clk); oc_flt = 1'b1; #1;
        chk("R2 drv cut same cycle", drv_en, 0);
        chk("R3 soft-off on fault", soft_off_en, 1);
        chk("R4 pd not before edge", pull_dn_en, 0);
        step(); oc_flt = 1'b0; #1;
        chk("R4 pd after edge", pull_dn_en, 1);
        chk("R3 soft-off in hold", soft_off_en, 1);
        chk("R2 drv off in hold", drv_en, 0);
        repeat (30) step();
        back_to_run();

        // R4: single-cycle fault gives exactly CLR
        fault_run(0, 1, 0, 0, pd);
        chk("R4 short pulse len", pd, CLR);
        back_to_run();
        chk("R7 resumes after recharge", drv_en, 1);

        // R5: long fault
        fault_run(1, 35, 0, 0, pd);
        chk("R5 long pulse len", pd, 35);
        back_to_run();
        fault_run(2, CLR, 0, 0, pd);
        chk("R5 equal pulse len", pd, CLR);
        back_to_run();

        // R6: second fault extends, short one does not shorten
        fault_run(0, 1, 10, 15, pd);
        chk("R6 extended pulse len", pd, 25);
        back_to_run();
        fault_run(1, 1, 5, 2, pd);
        chk("R6 short second fault", pd, CLR);
        back_to_run();

        // R7: slow recharge keeps output off
        @(negedge clk); rc_hold = 1'b1; oc_flt = 1'b1;
        step(); oc_flt = 1'b0;
        repeat (CLR + 10) step();
        chk("R7 pd released", pull_dn_en, 0);
        chk("R7 drv off while pin not high", drv_en, 0);
        @(negedge clk); rc_hold = 1'b0;
        step(); step();
        chk("R7 drv off two edges", drv_en, 0);
        step();
        chk("R7 drv on third edge", drv_en, 1);

        // R8: external shutdown
        @(negedge clk); ext_low = 1'b1; rc_hold = 1'b1; #1;
        step();
        chk("R8 drv one edge", drv_en, 1);
        step();
        chk("R8 drv cut after sync", drv_en, 0);
        repeat (5) step();
        chk("R8 no internal pd", pull_dn_en, 0);
        // R11: fault during external shutdown
        @(negedge clk); dsat_flt = 1'b1;
        step(); dsat_flt = 1'b0; #1;
        chk("R11 pd from ext sd", pull_dn_en, 1);
        repeat (CLR + 5) step();
        chk("R8 still off while pin low", drv_en, 0);
        @(negedge clk); ext_low = 1'b0; rc_hold = 1'b0;
        step(); step();
        chk("R8 drv off two edges", drv_en, 0);
        step();
        chk("R8 drv resumes", drv_en, 1);

        finish_run();
    end
endmodule